// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer. It is clocked by the output of an external dual-modulus prescaler, so one clock edge is one prescaler output pulse. The block drives the prescaler's modulus-control line and counts its output pulses. It emits one divided pulse per programmed total ratio of P·B+A oscillator cycles, where P is the prescaler's lower modulus. Each division cycle lasts B prescaler pulses. During the first A of them the prescaler divides by P+1, and during the remaining B−A it divides by P.

The swallow value A (7 bits), the main value B (11 bits) and the prescaler-size select are sampled only at a cycle boundary. A division cycle therefore always runs to completion with the values it started with. Illegal values are clamped: B is raised to at least 3, and A is limited both to P−1 and to B. A synchronous counter reset clears the divider so that it restarts on the first pulse after release. Powerdown freezes the counters and holds both control outputs low.

Top module: `swallow_div`

## Requirements
- R1: Between two consecutive `div_o` pulses the prescaler input sees exactly P·B+A oscillator cycles. Each clock with `mod_o`=1 counts P+1 and each clock with `mod_o`=0 counts P, using the effective (clamped) A and B.
- R2: Within a division cycle of B clocks, `mod_o` is 1 (divide by P+1) for the first A clocks and 0 for the remaining B−A clocks.
- R3: `psel_i`=0 selects P=64 and `psel_i`=1 selects P=128. `psel_o` drives the prescaler size and changes only on the clock edge that starts a division cycle.
- R4: `swallow_i` and `main_i` are sampled only on the edge that starts a division cycle. A change in the middle of a cycle neither shortens nor lengthens that cycle.
- R5: A `main_i` value below 3 is treated as 3.
- R6: The effective A is the smallest of `swallow_i`, P−1 and the effective B.
- R7: `div_o` is high for exactly one clock: the first clock of each division cycle that follows a completed cycle. It stays low on the first cycle after a reset, a counter reset or a start.
- R8: While `cnt_rst_i`=1 at a clock edge, the divider is cleared and `mod_o` and `div_o` are 0. The first edge with `cnt_rst_i`=0 starts a fresh cycle with newly sampled values.
- R9: While `pwdn_i`=1, `mod_o` and `div_o` are 0 and the counters hold. After release, counting continues from the held position.
- R10: While `rst_ni` is low, `mod_o`, `div_o` and `psel_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock; one edge per prescaler pulse |
| rst_ni | input | 1 | Asynchronous active-low reset |
| swallow_i | input | 7 | Programmed swallow count A |
| main_i | input | 11 | Programmed main count B |
| psel_i | input | 1 | Prescaler size: 0 = 64/65, 1 = 128/129 |
| cnt_rst_i | input | 1 | Synchronous counter reset |
| pwdn_i | input | 1 | Powerdown: freeze counters, outputs low |
| mod_o | output | 1 | Modulus control: 1 = divide by P+1, 0 = divide by P |
| div_o | output | 1 | Divided output pulse, one clock wide |
| psel_o | output | 1 | Prescaler size for the running cycle |

## Verification
A new A, B or P becomes visible on the first clock of the next cycle. That is one edge after the last pulse of the running cycle, and `div_o` rises in the same clock. `cnt_rst_i` and `pwdn_i` act at the next edge, and `pwdn_i` also masks the outputs at once. The bench drives inputs on the falling edge and compares all three outputs 1 ns later against a behavioural model stepped on each rising edge, so combinational masking and registered state are both observed where they become due. Each completed cycle is also weighed by accumulating P or P+1 per clock and comparing the sum with P·B+A when the next `div_o` arrives.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned SW_A_W   = 7;
  localparam int unsigned SW_B_W   = 11;
  localparam int unsigned SW_P_LOG = 6;   // small prescaler = 2**SW_P_LOG
  localparam int unsigned SW_B_MIN = 3;
endpackage

// File: rtl/sw_down_cnt.sv
module sw_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         one_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == W'(1));
endmodule

// File: rtl/sw_ratio_clamp.sv
module sw_ratio_clamp #(
  parameter int unsigned A_W   = 7,
  parameter int unsigned B_W   = 11,
  parameter int unsigned P_LOG = 6,
  parameter int unsigned B_MIN = 3
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           p_big_i,
  output logic [A_W-1:0] a_o,
  output logic [B_W-1:0] b_o
);
  localparam int unsigned P_SMALL = 1 << P_LOG;
  localparam int unsigned P_BIG   = 1 << (P_LOG + 1);
  localparam logic [A_W-1:0] A_CAP_S = A_W'(P_SMALL - 1);
  localparam logic [A_W-1:0] A_CAP_B = A_W'(P_BIG - 1);

  logic [A_W-1:0] a_cap;
  logic [A_W-1:0] a_p;
  logic [B_W-1:0] a_ext;

  assign b_o   = (b_i < B_W'(B_MIN)) ? B_W'(B_MIN) : b_i;
  assign a_cap = p_big_i ? A_CAP_B : A_CAP_S;
  assign a_p   = (a_i > a_cap) ? a_cap : a_i;

  // widen A before comparing against B
  generate
    if (B_W > A_W) begin : g_pad
      assign a_ext = {{(B_W-A_W){1'b0}}, a_p};
    end else begin : g_nopad
      assign a_ext = B_W'(a_p);
    end
  endgenerate

  assign a_o = (a_ext > b_o) ? A_W'(b_o) : a_p;
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import sw_pkg::*;
#(
  parameter int unsigned A_W   = SW_A_W,
  parameter int unsigned B_W   = SW_B_W,
  parameter int unsigned P_LOG = SW_P_LOG,
  parameter int unsigned B_MIN = SW_B_MIN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  input  logic           psel_i,
  input  logic           cnt_rst_i,
  input  logic           pwdn_i,
  output logic           mod_o,
  output logic           div_o,
  output logic           psel_o
);
  logic [A_W-1:0] a_eff, a_cnt;
  logic [B_W-1:0] b_eff, b_cnt;
  logic a_zero, a_one, b_zero, b_one;
  logic run_q, div_q, psel_q;
  logic active_w, load_w, dec_w;

  assign active_w = ~cnt_rst_i & ~pwdn_i;
  assign load_w   = active_w & (~run_q | b_one);
  assign dec_w    = active_w & run_q & ~b_one;

  sw_ratio_clamp #(
    .A_W(A_W), .B_W(B_W), .P_LOG(P_LOG), .B_MIN(B_MIN)
  ) i_clamp (
    .a_i     (swallow_i),
    .b_i     (main_i),
    .p_big_i (psel_i),
    .a_o     (a_eff),
    .b_o     (b_eff)
  );

  sw_down_cnt #(.W(A_W)) i_a_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_rst_i),
    .load_i     (load_w),
    .load_val_i (a_eff),
    .dec_i      (dec_w),
    .cnt_o      (a_cnt),
    .zero_o     (a_zero),
    .one_o      (a_one)
  );

  sw_down_cnt #(.W(B_W)) i_b_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cnt_rst_i),
    .load_i     (load_w),
    .load_val_i (b_eff),
    .dec_i      (dec_w),
    .cnt_o      (b_cnt),
    .zero_o     (b_zero),
    .one_o      (b_one)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      div_q  <= 1'b0;
      psel_q <= 1'b0;
    end else if (cnt_rst_i) begin
      run_q  <= 1'b0;
      div_q  <= 1'b0;
    end else if (pwdn_i) begin
      div_q  <= 1'b0;
    end else begin
      div_q <= load_w & run_q;  // no pulse on the very first cycle
      if (load_w) begin
        run_q  <= 1'b1;
        psel_q <= psel_i;
      end
    end
  end

  assign mod_o  = run_q & ~a_zero & ~pwdn_i;
  assign div_o  = div_q & ~pwdn_i;
  assign psel_o = psel_q;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int unsigned A_W = 7,
  parameter int unsigned B_W = 11
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cnt_rst_i,
  input logic           pwdn_i,
  input logic           mod_o,
  input logic           div_o,
  input logic           psel_o,
  input logic           load_w,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt
);
  AST_DIV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o); // R7

  AST_PWDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |-> (!mod_o && !div_o)); // R9

  AST_CRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_i |=> (!mod_o && !div_o) || pwdn_i); // R8

  AST_PSEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(psel_o) |-> $past(load_w)); // R3

  AST_SWALLOW_LE_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{(B_W-A_W){1'b0}}, a_cnt} <= b_cnt); // R6
endmodule

bind swallow_div swallow_div_chk #(.A_W(A_W), .B_W(B_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_rst_i (cnt_rst_i),
  .pwdn_i    (pwdn_i),
  .mod_o     (mod_o),
  .div_o     (div_o),
  .psel_o    (psel_o),
  .load_w    (load_w),
  .a_cnt     (a_cnt),
  .b_cnt     (b_cnt)
);

// File: tb/test_swallow_div.sv
`timescale 1ns/1ps
module test_swallow_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  swallow_i = '0;
  logic [10:0] main_i = 11'd3;
  logic        psel_i = 1'b0;
  logic        cnt_rst_i = 1'b0;
  logic        pwdn_i = 1'b0;
  logic        mod_o, div_o, psel_o;

  int checks = 0;
  int errors = 0;
  string phase = "R10";

  always #2.5 clk_i = ~clk_i;

  swallow_div i_swallow_div (
    .clk_i, .rst_ni, .swallow_i, .main_i, .psel_i,
    .cnt_rst_i, .pwdn_i, .mod_o, .div_o, .psel_o
  );

  // behavioural reference
  bit m_run, m_divq, m_psel, m_fresh;
  int m_ra, m_rb, m_ratio, m_prev_ratio;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_divq = 0; m_psel = 0; m_ra = 0; m_rb = 0; m_fresh = 0;
    end else if (cnt_rst_i) begin
      m_run = 0; m_divq = 0; m_ra = 0; m_rb = 0;
    end else if (pwdn_i) begin
      m_divq = 0;
    end else if (!m_run || m_rb == 1) begin
      int p, b, a;
      p = psel_i ? 128 : 64;
      b = (main_i < 3) ? 3 : int'(main_i);
      a = int'(swallow_i);
      if (a > p - 1) a = p - 1;
      if (a > b) a = b;
      m_divq = m_run;
      m_run = 1; m_rb = b; m_ra = a; m_psel = psel_i;
      m_prev_ratio = m_ratio;
      m_ratio = p * b + a;
      m_fresh = 1;
    end else begin
      m_rb--;
      if (m_ra > 0) m_ra--;
      m_divq = 0;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (%s, phase %s): got %0d expected %0d", req, what, phase, got, exp);
    end
  endtask

  // compare 1 ns after the falling edge, after inputs have been driven
  int acc = 0;
  bit acc_valid = 0;
  always @(negedge clk_i) begin
    #1;
    begin
      bit e_mod, e_div;
      e_mod = m_run && m_ra != 0 && !pwdn_i && rst_ni;
      e_div = m_divq && !pwdn_i && rst_ni;
      chk(pwdn_i ? "R9" : (rst_ni ? "R2" : "R10"), "mod_o", mod_o, e_mod);
      chk(pwdn_i ? "R9" : (rst_ni ? "R7" : "R10"), "div_o", div_o, e_div);
      chk(rst_ni ? "R3" : "R10", "psel_o", psel_o, m_psel);
      if (!rst_ni || cnt_rst_i || pwdn_i) acc_valid = 0;
      if (m_fresh) begin
        if (div_o && acc_valid) chk("R1", "oscillator cycles per output pulse", acc, m_prev_ratio);
        acc = 0; acc_valid = 1; m_fresh = 0;
      end
      if (m_run && !pwdn_i && rst_ni)
        acc += (m_psel ? 128 : 64) + (e_mod ? 1 : 0);
    end
  end

  task automatic cfg(int a, int b, bit p);
    @(negedge clk_i);
    swallow_i = 7'(a); main_i = 11'(b); psel_i = p;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // clocks between two div_o pulses, observed at the ports
  task automatic period_is(string req, int exp);
    int n;
    n = 0;
    while (div_o !== 1'b1) @(negedge clk_i);
    @(negedge clk_i);
    while (div_o !== 1'b1) begin n++; @(negedge clk_i); end
    chk(req, "clocks per division cycle", n + 1, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(4);                                   // R10 compared while held
    @(negedge clk_i); rst_ni = 1'b1;
    phase = "R2"; cfg(5, 10, 0); run(60);
    phase = "R4"; cfg(0, 3, 0); run(25);      // mid-cycle change
    cfg(9, 12, 0); run(3); cfg(1, 4, 0); run(30);
    phase = "R3"; cfg(127, 200, 1); run(450);
    cfg(20, 40, 0); run(100);
    phase = "R5"; cfg(2, 1, 0); period_is("R5", 3); run(10);
    cfg(0, 0, 1); period_is("R5", 3); run(10);
    phase = "R6"; cfg(100, 80, 0); run(200);  // A capped to 63
    cfg(90, 30, 1); run(100);                 // A capped to B
    cfg(127, 127, 1); run(300);
    phase = "R8"; cfg(6, 15, 0); run(20);
    @(negedge clk_i); cnt_rst_i = 1'b1; run(3);
    @(negedge clk_i); cnt_rst_i = 1'b0; run(50);
    phase = "R9"; run(4);
    @(negedge clk_i); pwdn_i = 1'b1; run(6);
    @(negedge clk_i); pwdn_i = 1'b0; run(50);
    period_is("R9", 15);
    phase = "R10"; @(negedge clk_i); rst_ni = 1'b0; run(3);
    @(negedge clk_i); rst_ni = 1'b1;
    phase = "R1"; cfg(33, 500, 1); run(1100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule